// File: doc/BRIEF.md
# Programmable I2C Bus Timing Generator

This block turns four count inputs into the SCL waveform and the START, repeated START and STOP conditions of an I2C controller. The counts are in system clocks. The first is the whole SCL period, normally the input clock rate divided by the bus rate: standard mode at 100 kHz is the default target and fast mode at 400 kHz is the fastest. The second is the low part of the period, normally five ninths of the period, which meets the low and high minimums of both modes. The third is the condition setup/hold time, normally half the period. The fourth is the delay from SCL falling to SDA changing, normally one sixteenth of the period.

A byte engine sends one bus step at a time over a valid/ready command port. The step is a START, a data bit or a STOP. The block reports the step's progress on four single-cycle ticks: SDA driven, SCL released, SDA sampled, step finished. Both lines are open drain. The block only ever pulls a line low or lets it go.

A recovery mode hands SCL to a software-controlled bit so that a stuck target can be clocked free. A 4-bit monitor reports the driven and the sampled level of each line. Line inputs pass through a synchronizer before they are used.

Top module: `i2c_timing_gen`

## Requirements
- R1: After reset, both lines are released, `rx_bit` is 0, `cmd_ready` is 1, all ticks are 0, and `line_mon` settles to 4'b1111.
- R2: The effective low length is L = max(`cfg_low`, 2). A data-bit step pulls SCL low during its first L cycles. `tick_rise` pulses in the last of those cycles, and SCL is released in the next cycle.
- R3: The effective high length is H = `cfg_period` − L when that is at least 2, and otherwise H = 2. A data-bit step holds SCL released for H cycles, pulses `tick_end` in the last one, and pulls SCL low again afterwards. The whole step lasts L+H cycles.
- R4: The effective data setup is D = min(`cfg_dsetup`, L−2). `tick_sda` pulses in cycle D of the low phase, and SDA takes its new value in the following cycle. SCL is always still held low at that point.
- R5: `tick_sample` pulses in cycle (H−1)/2 of the high phase (integer division). At that edge, `rx_bit` captures the synchronized SDA level. A step's four ticks never overlap one another.
- R6: The effective setup length is S = max(`cfg_setup`, 1). A START on an idle bus pulls SDA low for S cycles with SCL released, pulls SCL low after that, and ends with a `tick_end`.
- R7: A START while SCL is parked low is a repeated START. SDA is released at cycle D of a low phase of L cycles. SCL is then released for S cycles. SDA is then pulled low for another S cycles, and SCL is parked low. The step lasts L+2S cycles.
- R8: A STOP while SCL is parked low pulls SDA low at cycle D of a low phase of L cycles and releases SCL for S cycles. Both lines are then released, and the step lasts L+S cycles. A STOP on an idle bus lasts S cycles and leaves both lines released.
- R9: While `rec_normal` is 0, SCL is pulled exactly when `rec_scl_rel` is 0, SDA is released, and `cmd_ready` is 0. The sequencer returns to the idle state.
- R10: `line_mon` bit 3 is the driven SDA level, bit 2 the synchronized SDA input, bit 1 the driven SCL level and bit 0 the synchronized SCL input. A driven level is 1 when the line is released.
- R11: `cmd_ready` is 1 only while no step is in progress and the block is in normal mode. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and the engine holds the command until then. `cmd_op` codes: 0 START, 1 data bit, 2 STOP, 3 data bit. For a data bit, `cmd_bit` is the SDA value to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | System clocks per SCL period |
| cfg_low | input | CNT_W | System clocks of SCL low |
| cfg_setup | input | CNT_W | START/STOP setup and hold clocks |
| cfg_dsetup | input | CNT_W | Clocks from SCL falling to SDA change |
| rec_normal | input | 1 | 1 = normal operation, 0 = recovery mode |
| rec_scl_rel | input | 1 | Recovery SCL control: 1 releases, 0 pulls low |
| cmd_valid | input | 1 | Step command valid |
| cmd_ready | output | 1 | Step command accepted when high with valid |
| cmd_op | input | 2 | Step code (see R11) |
| cmd_bit | input | 1 | Data bit value for a data-bit step |
| tick_sda | output | 1 | SDA is being updated this cycle |
| tick_rise | output | 1 | Last SCL-low cycle of a low phase |
| tick_sample | output | 1 | SDA sample cycle |
| tick_end | output | 1 | Last cycle of the step |
| rx_bit | output | 1 | Last sampled SDA value |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| line_mon | output | 4 | Line monitor (see R10) |

## Verification
The bench builds the block with an 8-bit count width and a two-stage synchronizer. The 8-bit width makes the all-ones corner of the period count (255) affordable within a step. It also keeps small counts, where every clamp engages, quick to reach. Small counts reach a low count of zero, a period shorter than the low count, a data setup beyond the low phase and a zero setup count. The two-stage synchronizer lets the sample point of the shortest high phase fall on an SDA value that is still settling through the synchronizer. The bench orders the steps so that the expected bit stays the same in that case.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_BIT     = 2'd1,
    OP_STOP    = 2'd2,
    OP_BIT_ALT = 2'd3
  } step_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_SETHI = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_e;

  function automatic logic op_is_bit(input logic [1:0] op);
    return (op == OP_BIT) || (op == OP_BIT_ALT);
  endfunction

endpackage

// File: rtl/i2c_tg_timing.sv
module i2c_tg_timing #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] low,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] dsetup,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] set_len,
  output logic [CNT_W-1:0] dsu_idx,
  output logic [CNT_W-1:0] smp_idx
);

  localparam logic [CNT_W-1:0] MIN_PHASE = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] high_raw;
  logic [CNT_W-1:0] dsu_max;

  always_comb begin
    low_len  = (low < MIN_PHASE) ? MIN_PHASE : low;
    high_raw = period - low_len;
    if ((period > low_len) && (high_raw >= MIN_PHASE)) high_len = high_raw;
    else                                                high_len = MIN_PHASE;
    set_len  = (setup == '0) ? ONE : setup;
    dsu_max  = low_len - MIN_PHASE;
    dsu_idx  = (dsetup > dsu_max) ? dsu_max : dsetup;
    smp_idx  = (high_len - ONE) >> 1;
  end

endmodule

// File: rtl/i2c_tg_sync.sv
module i2c_tg_sync #(
  parameter int   STAGES  = 2,
  parameter int   W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {W{RST_VAL}};
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_tg_seq.sv
module i2c_tg_seq
  import i2c_tg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             normal,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] set_len,
  input  logic [CNT_W-1:0] dsu_idx,
  input  logic [CNT_W-1:0] smp_idx,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  input  logic             sda_s,
  output logic             tick_sda,
  output logic             tick_rise,
  output logic             tick_sample,
  output logic             tick_end,
  output logic             rx_bit,
  output logic             scl_q,
  output logic             sda_q,
  output seq_state_e       state
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       st;
  logic [1:0]       op_q;
  logic             tgt_q;
  logic [CNT_W-1:0] cnt;
  logic             rx_q;
  logic             fire;
  logic             low_last, high_last, set_last;

  assign cmd_ready = normal && ((st == ST_IDLE) || (st == ST_PARK));
  assign fire      = cmd_valid && cmd_ready;
  assign low_last  = (cnt == low_len  - ONE);
  assign high_last = (cnt == high_len - ONE);
  assign set_last  = (cnt == set_len  - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_q  <= OP_BIT;
      tgt_q <= 1'b0;
      cnt   <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
      rx_q  <= 1'b0;
    end else if (!normal) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_PARK: begin
          if (fire) begin
            cnt  <= '0;
            op_q <= cmd_op;
            if (cmd_op == OP_START) begin
              if (st == ST_IDLE) begin
                st    <= ST_HOLD;
                sda_q <= 1'b1;
              end else begin
                st    <= ST_LOW;
                tgt_q <= 1'b0;
              end
            end else if (cmd_op == OP_STOP) begin
              if (st == ST_IDLE) st <= ST_SETHI;
              else begin
                st    <= ST_LOW;
                tgt_q <= 1'b1;
              end
            end else begin
              st    <= ST_LOW;
              scl_q <= 1'b1;
              tgt_q <= ~cmd_bit;
            end
          end
        end
        ST_LOW: begin
          if (cnt == dsu_idx) sda_q <= tgt_q;
          if (low_last) begin
            cnt   <= '0;
            scl_q <= 1'b0;
            st    <= op_is_bit(op_q) ? ST_HIGH : ST_SETHI;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_HIGH: begin
          if (cnt == smp_idx) rx_q <= sda_s;
          if (high_last) begin
            cnt   <= '0;
            scl_q <= 1'b1;
            st    <= ST_PARK;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_SETHI: begin
          if (set_last) begin
            cnt <= '0;
            if (op_q == OP_START) begin
              st    <= ST_HOLD;
              sda_q <= 1'b1;
            end else begin
              st    <= ST_IDLE;
              sda_q <= 1'b0;
            end
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_HOLD: begin
          if (set_last) begin
            cnt   <= '0;
            scl_q <= 1'b1;
            st    <= ST_PARK;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tick_sda    = normal && (st == ST_LOW)  && (cnt == dsu_idx);
    tick_rise   = normal && (st == ST_LOW)  && low_last;
    tick_sample = normal && (st == ST_HIGH) && (cnt == smp_idx);
    tick_end    = normal && (((st == ST_HIGH) && high_last) ||
                             ((st == ST_SETHI) && set_last && (op_q == OP_STOP)) ||
                             ((st == ST_HOLD) && set_last));
  end

  assign rx_bit = rx_q;
  assign state  = st;

endmodule

// File: rtl/i2c_timing_gen.sv
module i2c_timing_gen
  import i2c_tg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_dsetup,
  input  logic             rec_normal,
  input  logic             rec_scl_rel,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             tick_sda,
  output logic             tick_rise,
  output logic             tick_sample,
  output logic             tick_end,
  output logic             rx_bit,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic [3:0]       line_mon
);

  logic [CNT_W-1:0] low_len, high_len, set_len, dsu_idx, smp_idx;
  logic [1:0]       lines_s;
  logic             seq_scl, seq_sda;
  seq_state_e       fsm_state;

  i2c_tg_timing #(.CNT_W(CNT_W)) u_timing (
    .period   (cfg_period),
    .low      (cfg_low),
    .setup    (cfg_setup),
    .dsetup   (cfg_dsetup),
    .low_len  (low_len),
    .high_len (high_len),
    .set_len  (set_len),
    .dsu_idx  (dsu_idx),
    .smp_idx  (smp_idx)
  );

  i2c_tg_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sda_in, scl_in}),
    .q     (lines_s)
  );

  i2c_tg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .normal      (rec_normal),
    .low_len     (low_len),
    .high_len    (high_len),
    .set_len     (set_len),
    .dsu_idx     (dsu_idx),
    .smp_idx     (smp_idx),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_bit     (cmd_bit),
    .sda_s       (lines_s[1]),
    .tick_sda    (tick_sda),
    .tick_rise   (tick_rise),
    .tick_sample (tick_sample),
    .tick_end    (tick_end),
    .rx_bit      (rx_bit),
    .scl_q       (seq_scl),
    .sda_q       (seq_sda),
    .state       (fsm_state)
  );

  assign scl_pull = rec_normal ? seq_scl : ~rec_scl_rel;
  assign sda_pull = seq_sda;
  assign line_mon = {~sda_pull, lines_s[1], ~scl_pull, lines_s[0]};

endmodule

// File: rtl/i2c_tg_checker.sv
module i2c_tg_checker
  import i2c_tg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rec_normal,
  input logic       rec_scl_rel,
  input logic       cmd_ready,
  input logic       tick_sda,
  input logic       tick_rise,
  input logic       tick_sample,
  input logic       tick_end,
  input logic       scl_pull,
  input logic       sda_pull,
  input seq_state_e fsm_state
);

  p_sda_under_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sda |-> scl_pull);

  p_rise_releases_r2: assert property (@(posedge clk) disable iff (!rst_n || !rec_normal)
    tick_rise |=> !scl_pull);

  p_high_sda_stable_r4: assert property (@(posedge clk) disable iff (!rst_n || !rec_normal)
    (fsm_state == ST_HIGH && $past(fsm_state == ST_HIGH)) |-> $stable(sda_pull));

  p_ticks_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_sda, tick_rise, tick_sample, tick_end}));

  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(tick_sda || tick_rise || tick_sample || tick_end));

  p_recovery_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_normal |-> (!cmd_ready && (scl_pull != rec_scl_rel)));

  p_recovery_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_normal) |=> (fsm_state == ST_IDLE && !sda_pull));

  p_end_parks_r3: assert property (@(posedge clk) disable iff (!rst_n || !rec_normal)
    (tick_end && fsm_state != ST_SETHI) |=> scl_pull);

endmodule

bind i2c_timing_gen i2c_tg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_normal  (rec_normal),
  .rec_scl_rel (rec_scl_rel),
  .cmd_ready   (cmd_ready),
  .tick_sda    (tick_sda),
  .tick_rise   (tick_rise),
  .tick_sample (tick_sample),
  .tick_end    (tick_end),
  .scl_pull    (scl_pull),
  .sda_pull    (sda_pull),
  .fsm_state   (fsm_state)
);

// File: tb/tb_i2c_timing_gen.sv
`timescale 1ns/1ps
module tb_i2c_timing_gen;

  localparam int CW = 8;

  typedef struct packed {
    logic [1:0]    op;
    logic          b;
    logic          tg;
    logic [CW-1:0] cyc;
    logic [CW-1:0] low;
    logic [CW-1:0] sst;
    logic [CW-1:0] dsu;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'd20,  8'd11,  8'd10, 8'd1},
    '{2'd1, 1'b1, 1'b0, 8'd20,  8'd11,  8'd10, 8'd1},
    '{2'd1, 1'b1, 1'b1, 8'd20,  8'd11,  8'd10, 8'd1},
    '{2'd3, 1'b0, 1'b0, 8'd20,  8'd11,  8'd10, 8'd1},
    '{2'd1, 1'b1, 1'b0, 8'd255, 8'd140, 8'd0,  8'd30},
    '{2'd1, 1'b1, 1'b0, 8'd0,   8'd0,   8'd0,  8'd5},
    '{2'd1, 1'b0, 1'b0, 8'd10,  8'd6,   8'd2,  8'd50},
    '{2'd0, 1'b0, 1'b0, 8'd20,  8'd11,  8'd4,  8'd1},
    '{2'd1, 1'b0, 1'b0, 8'd20,  8'd11,  8'd4,  8'd1},
    '{2'd2, 1'b0, 1'b0, 8'd20,  8'd11,  8'd4,  8'd1},
    '{2'd2, 1'b0, 1'b0, 8'd20,  8'd11,  8'd3,  8'd1},
    '{2'd1, 1'b1, 1'b0, 8'd12,  8'd5,   8'd3,  8'd2},
    '{2'd2, 1'b0, 1'b0, 8'd12,  8'd5,   8'd3,  8'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_setup = '0, cfg_dsetup = '0;
  logic          rec_normal = 1'b1, rec_scl_rel = 1'b1;
  logic          cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic          cmd_ready, tick_sda, tick_rise, tick_sample, tick_end, rx_bit;
  logic          scl_pull, sda_pull, tgt_pull = 1'b0;
  logic [3:0]    line_mon;
  wire           scl_in = ~scl_pull;
  wire           sda_in = ~(sda_pull | tgt_pull);

  int n_chk = 0;
  int n_err = 0;
  bit parked = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_timing_gen #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_setup(cfg_setup), .cfg_dsetup(cfg_dsetup),
    .rec_normal(rec_normal), .rec_scl_rel(rec_scl_rel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .tick_sda(tick_sda), .tick_rise(tick_rise), .tick_sample(tick_sample), .tick_end(tick_end),
    .rx_bit(rx_bit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .line_mon(line_mon)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    int L, H, S, D, e_tot, e_sda, e_rise, e_smp, e_lowc, e_scl, e_sda_end;
    int idx, f_sda, f_rise, f_smp, lowc;
    bit busy_ready, is_bit;
    L = (int'(v.low) < 2) ? 2 : int'(v.low);
    H = (int'(v.cyc) - L >= 2) ? int'(v.cyc) - L : 2;
    S = (v.sst == 0) ? 1 : int'(v.sst);
    D = (int'(v.dsu) > L - 2) ? L - 2 : int'(v.dsu);
    is_bit = (v.op == 2'd1) || (v.op == 2'd3);
    e_sda = -1; e_rise = -1; e_smp = -1; e_lowc = 0;
    if (is_bit) begin
      e_tot = L + H; e_sda = D; e_rise = L - 1; e_smp = L + (H - 1) / 2; e_lowc = L;
      e_scl = 1; e_sda_end = v.b ? 0 : 1;
    end else if (v.op == 2'd0) begin
      if (parked) begin
        e_tot = L + 2 * S; e_sda = D; e_rise = L - 1; e_lowc = L;
      end else e_tot = S;
      e_scl = 1; e_sda_end = 1;
    end else begin
      if (parked) begin
        e_tot = L + S; e_sda = D; e_rise = L - 1; e_lowc = L;
      end else e_tot = S;
      e_scl = 0; e_sda_end = 0;
    end
    cfg_period = v.cyc; cfg_low = v.low; cfg_setup = v.sst; cfg_dsetup = v.dsu;
    tgt_pull = v.tg;
    @(negedge clk);
    cmd_op = v.op; cmd_bit = v.b; cmd_valid = 1'b1;
    check("R11 ready between steps", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    idx = 0; f_sda = -1; f_rise = -1; f_smp = -1; lowc = 0; busy_ready = 1'b0;
    forever begin
      if (tick_sda && f_sda < 0) f_sda = idx;
      if (tick_rise && f_rise < 0) f_rise = idx;
      if (tick_sample && f_smp < 0) f_smp = idx;
      if (scl_pull) lowc++;
      if (cmd_ready) busy_ready = 1'b1;
      if (tick_end || idx > 2000) break;
      @(negedge clk);
      idx++;
    end
    check("R3/R6/R7/R8 step length", idx + 1, e_tot);
    check("R4 tick_sda cycle", f_sda, e_sda);
    check("R2 tick_rise cycle", f_rise, e_rise);
    check("R5 tick_sample cycle", f_smp, e_smp);
    check("R2 SCL low cycles", lowc, e_lowc);
    check("R11 ready withheld during step", int'(busy_ready), 0);
    @(negedge clk);
    check("R3/R6/R8 SCL pull after step", int'(scl_pull), e_scl);
    check("R4/R7/R8 SDA pull after step", int'(sda_pull), e_sda_end);
    if (is_bit) check("R5 rx_bit", int'(rx_bit), int'(v.b & ~v.tg));
    tgt_pull = 1'b0;
    parked = (e_scl == 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 scl released", int'(scl_pull), 0);
    check("R1 sda released", int'(sda_pull), 0);
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 ticks quiet", int'({tick_sda, tick_rise, tick_sample, tick_end}), 0);
    check("R1 rx_bit", int'(rx_bit), 0);
    repeat (3) @(negedge clk);
    check("R1 monitor idle", int'(line_mon), 4'b1111);

    for (int i = 0; i < NV; i++) run_op(TBL[i]);

    // R10 monitor with both lines held low after a START
    run_op('{2'd0, 1'b0, 1'b0, 8'd20, 8'd11, 8'd4, 8'd1});
    repeat (3) @(negedge clk);
    check("R10 monitor parked", int'(line_mon), 4'b0000);

    // R9 recovery: SCL follows the software bit
    rec_normal = 1'b0; rec_scl_rel = 1'b0;
    @(negedge clk);
    check("R9 scl pulled by software", int'(scl_pull), 1);
    check("R9 sda released", int'(sda_pull), 0);
    check("R9 ready low", int'(cmd_ready), 0);
    repeat (3) @(negedge clk);
    check("R10 monitor recovery low", int'(line_mon), 4'b1100);
    rec_scl_rel = 1'b1;
    @(negedge clk);
    check("R9 scl released by software", int'(scl_pull), 0);
    repeat (3) @(negedge clk);
    check("R10 monitor recovery high", int'(line_mon), 4'b1111);
    rec_normal = 1'b1;
    @(negedge clk);
    check("R9 back to idle ready", int'(cmd_ready), 1);
    check("R9 back to idle scl", int'(scl_pull), 0);
    parked = 1'b0;
    run_op('{2'd0, 1'b0, 1'b0, 8'd20, 8'd11, 8'd2, 8'd1});
    run_op('{2'd2, 1'b0, 1'b0, 8'd20, 8'd11, 8'd2, 8'd1});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule